// File: doc/BRIEF.md
# Programmable Serial Port Register Bank

This block is the processor-facing side of a programmable asynchronous serial port. A host reaches it over a small register bus: a 3-bit offset, a read strobe, a write strobe, an 8-bit write bus and an 8-bit read bus. Read data is combinational and valid in the same cycle as the read strobe. Any side effect of a read takes place at the clock edge that closes that cycle.

The bank holds a 16-bit rate divisor and emits a one-cycle sampling tick. It drives four modem-control outputs and watches four modem-status inputs. It also folds four internal event sources into a single interrupt line. The bit shifter sits outside the block. It hands over each received byte, with its parity and framing error flags, on a one-cycle valid pulse. It reports whether its transmit holding stage is free. It receives each byte written by the host as a one-cycle push pulse.

Top module: `sio_regbank`

## Requirements
- R1: Offsets are 0 data, 1 interrupt enable, 2 interrupt identification, 3 line control, 4 modem control, 5 line status and 6 modem status. Bit 7 of line control selects the divisor bank: while it is 1, offset 0 reads and writes the divisor low byte and offset 1 the high byte. Line control bits 6:0 appear on `fmt_o`.
- R2: The divisor resets to 0, and while it is 0 `baud_tick_o` stays low.
- R3: With a divisor N ≥ 1, `baud_tick_o` is a one-cycle pulse every N clock cycles. For example, N=12 gives 10 ticks in 120 cycles.
- R4: Modem control bit 0 drives `dtr_o`, bit 1 `rts_o`, bit 2 `out1_o` and bit 3 `out2_o`.
- R5: Interrupt-enable bits are 0 receive data, 1 transmit holding empty, 2 line error and 3 modem status. Identification reads 0x06 for line error, 0x04 for receive data, 0x02 for transmit empty and 0x00 for modem status, with that order as the priority. It reads 0x01 when no enabled source is pending.
- R6: `irq_o` is high only when an enabled source is pending and modem control bit 3 is 1.
- R7: Modem status bits 4..7 show the synchronized CTS, DSR, RI and DCD. Bits 0, 1 and 3 are set when CTS, DSR or DCD change. Bit 2 is set when RI falls from 1 to 0.
- R8: Reading modem status clears bits 0..3 at the end of the read cycle. A change detected at that same edge stays set.
- R9: A received byte sets line status bit 0 (data ready) and is read at offset 0. Reading it clears data ready. A byte that arrives while data ready is set and not being read sets overrun (bit 1).
- R10: Line status bit 2 latches a parity error and bit 3 a framing error. Reading line status clears bits 1..3. Bit 5 mirrors `tx_hold_empty_i`.
- R11: A data write in bank 0 emits a one-cycle `tx_push_o` with the byte on `tx_data_o`. The transmit-empty interrupt is raised by a rising `tx_hold_empty_i`, or by enabling it while the holding stage is empty. It is cleared by a data write, or by reading identification while it reports 0x02.
- R12: After reset, line control, modem control, interrupt enable and every output are 0, identification reads 0x01, and line status reads 0x20 with the holding stage empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the divisor reference |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rx_valid_i | input | 1 | Received byte pulse from the shifter |
| rx_byte_i | input | 8 | Received byte |
| rx_parity_err_i | input | 1 | Parity error for this byte |
| rx_frame_err_i | input | 1 | Framing error for this byte |
| tx_hold_empty_i | input | 1 | Shifter transmit holding stage free |
| tx_push_o | output | 1 | Byte handed to the shifter |
| tx_data_o | output | 8 | Byte to transmit |
| fmt_o | output | 7 | Character format bits from line control |
| baud_tick_o | output | 1 | Sampling tick, 16 times the bit rate |
| cts_i | input | 1 | Clear-to-send input |
| dsr_i | input | 1 | Data-set-ready input |
| dcd_i | input | 1 | Carrier-detect input |
| ri_i | input | 1 | Ring-indicator input |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General modem output 1 |
| out2_o | output | 1 | Interrupt gate output 2 |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the interrupt line never rises while the gate bit is clear. They also check that the tick stays low with a zero divisor and is never high on two cycles in a row for divisors above one. Other per-cycle checks: modem delta bits only drop on a status read, at most one source wins arbitration, and a byte landing on unread data sets overrun. The bench scenarios show what only a sequence of accesses reveals. These are the bank-select aliasing of offsets 0 and 1, the exact tick period, the priority codes as sources are added and retired, clear-on-read, including a change that lands on the clearing edge, and the transmit-empty interrupt's set and clear paths.

// File: rtl/sio_pkg.sv
// Shared definitions for the serial port register bank.
// Assumes an 8-bit host bus with 3-bit offsets.
package sio_pkg;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int NUM_SRC = 4;
    localparam int NUM_MDM = 4;

    typedef enum logic [ADDR_W-1:0] {
        OFS_DATA  = 3'd0,
        OFS_IEN   = 3'd1,
        OFS_IID   = 3'd2,
        OFS_LCTL  = 3'd3,
        OFS_MCTL  = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_NONE  = 3'd7
    } reg_ofs_e;

    // Source index doubles as the identification code; higher wins.
    typedef enum logic [1:0] {
        SRC_MODEM = 2'd0,
        SRC_TXE   = 2'd1,
        SRC_RXD   = 2'd2,
        SRC_LINE  = 2'd3
    } irq_src_e;

    // Modem line index inside the status vector.
    localparam int MDM_CTS = 0;
    localparam int MDM_DSR = 1;
    localparam int MDM_RI  = 2;
    localparam int MDM_DCD = 3;
endpackage

// File: rtl/sio_baud_gen.sv
// Rate tick generator: divides the clock by a programmable divisor.
// Assumes the divisor is static between writes; restart realigns the count.
// A divisor of zero holds the tick low.
module sio_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             restart_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    // Count reference cycles and pulse on the last one of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (restart_i || divisor_i == '0) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (cnt_q >= divisor_i - 1'b1) begin
            cnt_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_modem_stat.sv
// Modem status tracker: synchronizes the four modem inputs, detects
// changes (falling edge only for ring indicator) and holds sticky delta bits
// until a status read. Assumes inputs are asynchronous to clk.
module sio_modem_stat #(
    parameter int SYNC_STAGES = 2,
    parameter int LINES       = sio_pkg::NUM_MDM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines_i,
    input  logic             clr_i,
    output logic [2*LINES-1:0] status_o,
    output logic             delta_any_o
);
    logic [SYNC_STAGES-1:0][LINES-1:0] stg_q;
    logic [LINES-1:0] now, prev_q, chg, delta_q;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= lines_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign now = stg_q[SYNC_STAGES-1];

    // Per-line change detector; ring indicator reports only its trailing edge.
    for (genvar k = 0; k < LINES; k++) begin : g_chg
        if (k == sio_pkg::MDM_RI) begin : g_trail
            assign chg[k] = prev_q[k] & ~now[k];
        end else begin : g_any
            assign chg[k] = prev_q[k] ^ now[k];
        end
    end

    // Remember the last level and accumulate deltas; new changes beat a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            delta_q <= '0;
        end else begin
            prev_q  <= now;
            delta_q <= (delta_q & ~{LINES{clr_i}}) | chg;
        end
    end

    assign status_o    = {now, delta_q};
    assign delta_any_o = |delta_q;
endmodule

// File: rtl/sio_irq_arb.sv
// Fixed-priority interrupt arbiter: the highest-index pending source wins.
// Assumes requests are already masked by their enables.
module sio_irq_arb #(
    parameter int NUM_SRC = sio_pkg::NUM_SRC,
    localparam int ID_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] req_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [ID_W-1:0]    id_o,
    output logic               pending_o
);
    // Scan upward so the last (highest) pending index overrides lower ones.
    always_comb begin
        grant_o = '0;
        id_o    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                id_o       = ID_W'(i);
            end
        end
    end

    assign pending_o = |req_i;
endmodule

// File: rtl/sio_regbank.sv
// Register bank of a programmable serial port. Decodes host accesses,
// holds divisor, format, enable and modem-control state, collects line
// and modem status and drives the gated interrupt. Assumes the shifter
// pulses rx_valid_i for one cycle per byte and consumes tx_push_o pulses.
module sio_regbank #(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       rx_parity_err_i,
    input  logic       rx_frame_err_i,
    input  logic       tx_hold_empty_i,
    output logic       tx_push_o,
    output logic [7:0] tx_data_o,
    output logic [6:0] fmt_o,
    output logic       baud_tick_o,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       dcd_i,
    input  logic       ri_i,
    output logic       dtr_o,
    output logic       rts_o,
    output logic       out1_o,
    output logic       out2_o,
    output logic       irq_o
);
    import sio_pkg::*;

    localparam int ID_W = $clog2(NUM_SRC);

    logic [7:0]       lcr_q;
    logic [3:0]       ier_q;
    logic [3:0]       mcr_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       rbr_q;
    logic             dr_q, oe_q, pe_q, fe_q;
    logic             thre_pend_q, txe_prev_q;
    logic             bank;
    logic             wr_data, wr_ien, wr_dll, wr_dlm;
    logic             rd_data, rd_lsr, rd_msr, rd_iid;
    logic [7:0]       msr_val;
    logic             msr_delta_any;
    logic [NUM_SRC-1:0] req, grant;
    logic [ID_W-1:0]  iid;
    logic             ipend;
    logic             thre_set, thre_clr;

    // Access decode; the bank bit re-routes offsets 0 and 1.
    assign bank    = lcr_q[7];
    assign wr_data = bus_wr && bus_addr == OFS_DATA && !bank;
    assign wr_ien  = bus_wr && bus_addr == OFS_IEN  && !bank;
    assign wr_dll  = bus_wr && bus_addr == OFS_DATA &&  bank;
    assign wr_dlm  = bus_wr && bus_addr == OFS_IEN  &&  bank;
    assign rd_data = bus_rd && bus_addr == OFS_DATA && !bank;
    assign rd_lsr  = bus_rd && bus_addr == OFS_LSTAT;
    assign rd_msr  = bus_rd && bus_addr == OFS_MSTAT;
    assign rd_iid  = bus_rd && bus_addr == OFS_IID;

    // Host-writable configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_q <= '0;
            ier_q <= '0;
            mcr_q <= '0;
            div_q <= '0;
        end else begin
            if (bus_wr && bus_addr == OFS_LCTL) lcr_q <= bus_wdata;
            if (bus_wr && bus_addr == OFS_MCTL) mcr_q <= bus_wdata[3:0];
            if (wr_ien) ier_q <= bus_wdata[3:0];
            if (wr_dll) div_q[7:0] <= bus_wdata;
            if (wr_dlm) div_q[DIV_W-1:8] <= bus_wdata[DIV_W-9:0];
        end
    end

    // Receive holding byte and line status flags; new events beat clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr_q <= '0;
            dr_q  <= 1'b0;
            oe_q  <= 1'b0;
            pe_q  <= 1'b0;
            fe_q  <= 1'b0;
        end else begin
            if (rx_valid_i) begin
                rbr_q <= rx_byte_i;
                dr_q  <= 1'b1;
            end else if (rd_data) begin
                dr_q  <= 1'b0;
            end
            oe_q <= (oe_q & ~rd_lsr) | (rx_valid_i & dr_q & ~rd_data);
            pe_q <= (pe_q & ~rd_lsr) | (rx_valid_i & rx_parity_err_i);
            fe_q <= (fe_q & ~rd_lsr) | (rx_valid_i & rx_frame_err_i);
        end
    end

    // Transmit-empty interrupt set and clear events.
    assign thre_set = (tx_hold_empty_i && !txe_prev_q)
                   || (wr_ien && bus_wdata[1] && !ier_q[1] && tx_hold_empty_i);
    assign thre_clr = wr_data || (rd_iid && grant[SRC_TXE]);

    // Transmit push pulse, empty-edge history and pending transmit interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_push_o   <= 1'b0;
            tx_data_o   <= '0;
            txe_prev_q  <= 1'b0;
            thre_pend_q <= 1'b0;
        end else begin
            tx_push_o  <= wr_data;
            if (wr_data) tx_data_o <= bus_wdata;
            txe_prev_q <= tx_hold_empty_i;
            if (thre_set) thre_pend_q <= 1'b1;
            else if (thre_clr) thre_pend_q <= 1'b0;
        end
    end

    sio_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor_i (div_q),
        .restart_i (wr_dll || wr_dlm),
        .tick_o    (baud_tick_o)
    );

    sio_modem_stat #(.SYNC_STAGES(SYNC_STAGES), .LINES(NUM_MDM)) u_mdm (
        .clk         (clk),
        .rst_n       (rst_n),
        .lines_i     ({dcd_i, ri_i, dsr_i, cts_i}),
        .clr_i       (rd_msr),
        .status_o    (msr_val),
        .delta_any_o (msr_delta_any)
    );

    // Masked interrupt requests, indexed by source code.
    always_comb begin
        req            = '0;
        req[SRC_LINE]  = ier_q[2] & (oe_q | pe_q | fe_q);
        req[SRC_RXD]   = ier_q[0] & dr_q;
        req[SRC_TXE]   = ier_q[1] & thre_pend_q;
        req[SRC_MODEM] = ier_q[3] & msr_delta_any;
    end

    sio_irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .req_i     (req),
        .grant_o   (grant),
        .id_o      (iid),
        .pending_o (ipend)
    );

    // Read multiplexer for the addressed register.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_DATA:  bus_rdata = bank ? div_q[7:0] : rbr_q;
            OFS_IEN:   bus_rdata = bank ? div_q[DIV_W-1:8] : {4'b0, ier_q};
            OFS_IID:   bus_rdata = {5'b0, iid, ~ipend};
            OFS_LCTL:  bus_rdata = lcr_q;
            OFS_MCTL:  bus_rdata = {4'b0, mcr_q};
            OFS_LSTAT: bus_rdata = {2'b0, tx_hold_empty_i, 1'b0, fe_q, pe_q, oe_q, dr_q};
            OFS_MSTAT: bus_rdata = msr_val;
            default:   bus_rdata = '0;
        endcase
    end

    assign fmt_o  = lcr_q[6:0];
    assign dtr_o  = mcr_q[0];
    assign rts_o  = mcr_q[1];
    assign out1_o = mcr_q[2];
    assign out2_o = mcr_q[3];
    assign irq_o  = ipend & mcr_q[3];
endmodule

// File: rtl/sio_regbank_chk.sv
// Property checker for the serial port register bank, bound to its top.
module sio_regbank_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_o,
    input logic             out2_o,
    input logic             baud_tick_o,
    input logic [DIV_W-1:0] div_q,
    input logic             bus_rd,
    input logic [2:0]       bus_addr,
    input logic [7:0]       msr_val,
    input logic [3:0]       grant,
    input logic             rx_valid_i,
    input logic             rd_data,
    input logic             dr_q,
    input logic             oe_q
);
    AST_IRQ_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> out2_o); // R6

    AST_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q == '0 && $past(div_q) == '0) |-> !baud_tick_o); // R2

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick_o && div_q > 1 && $stable(div_q)) |=> !baud_tick_o); // R3

    AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == 3'd6)
        |=> ((msr_val[3:0] & $past(msr_val[3:0])) == $past(msr_val[3:0]))); // R8

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5

    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && dr_q && !rd_data) |=> oe_q); // R9

    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_i |=> dr_q); // R9
endmodule

bind sio_regbank sio_regbank_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_o       (irq_o),
    .out2_o      (out2_o),
    .baud_tick_o (baud_tick_o),
    .div_q       (div_q),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .msr_val     (msr_val),
    .grant       (grant),
    .rx_valid_i  (rx_valid_i),
    .rd_data     (rd_data),
    .dr_q        (dr_q),
    .oe_q        (oe_q)
);

// File: tb/sio_regbank_tb.sv
// Directed bench for the serial port register bank.
module sio_regbank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = '0;
    logic       rx_parity_err_i = 1'b0, rx_frame_err_i = 1'b0;
    logic       tx_hold_empty_i = 1'b1;
    logic       tx_push_o;
    logic [7:0] tx_data_o;
    logic [6:0] fmt_o;
    logic       baud_tick_o;
    logic       cts_i = 1'b0, dsr_i = 1'b0, dcd_i = 1'b0, ri_i = 1'b0;
    logic       dtr_o, rts_o, out1_o, out2_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sio_regbank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .rx_parity_err_i(rx_parity_err_i), .rx_frame_err_i(rx_frame_err_i),
        .tx_hold_empty_i(tx_hold_empty_i), .tx_push_o(tx_push_o),
        .tx_data_o(tx_data_o), .fmt_o(fmt_o), .baud_tick_o(baud_tick_o),
        .cts_i(cts_i), .dsr_i(dsr_i), .dcd_i(dcd_i), .ri_i(ri_i),
        .dtr_o(dtr_o), .rts_o(rts_o), .out1_o(out1_o), .out2_o(out2_o),
        .irq_o(irq_o)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        reg_rd(a, d);
        check(d, exp, tag);
    endtask

    task automatic rx_push(input logic [7:0] b, input logic p, input logic f);
        @(negedge clk);
        rx_valid_i = 1'b1; rx_byte_i = b; rx_parity_err_i = p; rx_frame_err_i = f;
        @(posedge clk);
        #1 rx_valid_i = 1'b0; rx_parity_err_i = 1'b0; rx_frame_err_i = 1'b0;
    endtask

    task automatic count_ticks(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (baud_tick_o) n++;
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic t_reset();
        int n;
        rd_chk(3'd2, 8'h01, "R12 iid after reset");
        rd_chk(3'd3, 8'h00, "R12 lctl after reset");
        rd_chk(3'd4, 8'h00, "R12 mctl after reset");
        rd_chk(3'd1, 8'h00, "R12 ien after reset");
        rd_chk(3'd5, 8'h20, "R12 lstat after reset");
        rd_chk(3'd6, 8'h00, "R12 mstat after reset");
        check({dtr_o, rts_o, out1_o, out2_o, irq_o, tx_push_o}, 0, "R12 outputs low");
        count_ticks(50, n);
        check(n, 0, "R2 no tick with reset divisor");
    endtask

    task automatic t_bank_and_tick();
        int n;
        reg_wr(3'd3, 8'h80);
        reg_wr(3'd0, 8'h0C);
        reg_wr(3'd1, 8'h00);
        rd_chk(3'd0, 8'h0C, "R1 divisor low via bank");
        rd_chk(3'd1, 8'h00, "R1 divisor high via bank");
        reg_wr(3'd3, 8'h03);
        rd_chk(3'd3, 8'h03, "R1 lctl readback");
        check(fmt_o, 7'h03, "R1 fmt_o");
        reg_wr(3'd1, 8'h09);
        rd_chk(3'd1, 8'h09, "R1 ien in bank 0");
        reg_wr(3'd3, 8'h80);
        rd_chk(3'd0, 8'h0C, "R1 divisor kept under ien write");
        reg_wr(3'd3, 8'h03);
        count_ticks(120, n);
        check(n, 10, "R3 ticks for divisor 12");
        reg_wr(3'd3, 8'h83);
        reg_wr(3'd0, 8'h01);
        reg_wr(3'd3, 8'h03);
        count_ticks(40, n);
        check(n, 40, "R3 ticks for divisor 1");
        reg_wr(3'd3, 8'h83);
        reg_wr(3'd0, 8'h00);
        reg_wr(3'd3, 8'h03);
        count_ticks(60, n);
        check(n, 0, "R2 zero divisor stops tick");
    endtask

    task automatic t_modem_ctl();
        reg_wr(3'd4, 8'h0F);
        @(negedge clk);
        check({out2_o, out1_o, rts_o, dtr_o}, 4'hF, "R4 all modem outputs");
        reg_wr(3'd4, 8'h02);
        @(negedge clk);
        check({out2_o, out1_o, rts_o, dtr_o}, 4'h2, "R4 rts only");
        reg_wr(3'd4, 8'h05);
        @(negedge clk);
        check({out2_o, out1_o, rts_o, dtr_o}, 4'h5, "R4 dtr and out1");
        reg_wr(3'd4, 8'h00);
    endtask

    task automatic t_modem_stat();
        @(negedge clk) cts_i = 1'b1;
        settle();
        rd_chk(3'd6, 8'h11, "R7 cts delta and level");
        rd_chk(3'd6, 8'h10, "R8 read cleared delta");
        @(negedge clk) ri_i = 1'b1;
        settle();
        rd_chk(3'd6, 8'h50, "R7 ri rise gives no delta");
        @(negedge clk) ri_i = 1'b0;
        settle();
        rd_chk(3'd6, 8'h14, "R7 ri trailing edge");
        @(negedge clk) dcd_i = 1'b1;
        settle();
        rd_chk(3'd6, 8'h98, "R7 dcd delta and level");
        @(negedge clk) dcd_i = 1'b0;
        settle();
        rd_chk(3'd6, 8'h18, "R7 dcd fall delta");
        // Change reaches the delta bit on the very edge that ends the read.
        @(negedge clk) cts_i = 1'b0;
        @(posedge clk);
        @(posedge clk);
        rd_chk(3'd6, 8'h00, "R8 read in change cycle");
        rd_chk(3'd6, 8'h01, "R8 same-edge change kept");
        rd_chk(3'd6, 8'h00, "R8 cleared afterwards");
    endtask

    task automatic t_irq();
        reg_wr(3'd1, 8'h0F);
        reg_wr(3'd4, 8'h08);
        @(negedge clk);
        check(irq_o, 1, "R11 enabling txe while empty raises irq");
        rd_chk(3'd2, 8'h02, "R5 txe code");
        rd_chk(3'd2, 8'h01, "R11 iid read cleared txe");
        check(irq_o, 0, "R6 irq low when nothing pending");
        rx_push(8'hA5, 1'b0, 1'b0);
        rd_chk(3'd2, 8'h04, "R5 rx data code");
        check(irq_o, 1, "R6 irq for rx data");
        rx_push(8'h3C, 1'b1, 1'b0);
        rd_chk(3'd2, 8'h06, "R5 line error outranks rx data");
        rd_chk(3'd5, 8'h27, "R9 ready overrun parity");
        rd_chk(3'd5, 8'h21, "R10 errors cleared by read");
        rd_chk(3'd2, 8'h04, "R5 rx data after errors clear");
        rd_chk(3'd0, 8'h3C, "R9 latest byte");
        rd_chk(3'd2, 8'h01, "R9 data read clears ready");
        rx_push(8'h11, 1'b0, 1'b1);
        rd_chk(3'd5, 8'h29, "R10 framing error");
        rd_chk(3'd0, 8'h11, "R9 byte after framing error");
        rd_chk(3'd5, 8'h20, "R10 lstat clean");
        @(negedge clk) dsr_i = 1'b1;
        settle();
        rd_chk(3'd2, 8'h00, "R5 modem code");
        check(irq_o, 1, "R6 irq for modem change");
        reg_wr(3'd4, 8'h00);
        @(negedge clk);
        check(irq_o, 0, "R6 gate bit clear blocks irq");
        rd_chk(3'd2, 8'h00, "R6 source still pending when gated");
        rd_chk(3'd6, 8'h22, "R7 dsr delta and level");
        rd_chk(3'd2, 8'h01, "R8 msr read retires modem source");
        @(negedge clk) dsr_i = 1'b0;
        settle();
        rd_chk(3'd6, 8'h02, "R7 dsr fall delta");
    endtask

    task automatic t_tx();
        reg_wr(3'd0, 8'h5A);
        @(negedge clk);
        check({tx_push_o, tx_data_o}, {1'b1, 8'h5A}, "R11 push pulse with byte");
        @(negedge clk);
        check(tx_push_o, 0, "R11 push lasts one cycle");
        @(negedge clk) tx_hold_empty_i = 1'b0;
        rd_chk(3'd5, 8'h00, "R10 lstat tracks busy holding stage");
        @(negedge clk) tx_hold_empty_i = 1'b1;
        repeat (2) @(posedge clk);
        reg_wr(3'd4, 8'h08);
        @(negedge clk);
        check(irq_o, 1, "R11 empty rise raises irq");
        rd_chk(3'd5, 8'h20, "R10 lstat tracks free holding stage");
        reg_wr(3'd0, 8'h77);
        rd_chk(3'd2, 8'h01, "R11 data write clears txe");
        check(tx_data_o, 8'h77, "R11 second byte");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_bank_and_tick();
        t_modem_ctl();
        t_modem_stat();
        t_irq();
        t_tx();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule